// File: doc/BRIEF.md
# UART Interrupt Enable and Request Logic

This block keeps the four-bit interrupt mask of a serial port controller and turns the port's status conditions into one active-high interrupt request. Four sources can raise the request: received data is available, the transmit holding register is empty, the receiver has seen a line error, and a modem control input has changed. Each source has its own mask bit, which the processor writes and reads back through a byte-wide access port.

In FIFO mode, received data counts as available only when the receive FIFO holds at least the programmed trigger number of entries. The condition drops as soon as the fill falls below that number. With FIFO mode off, the plain data-ready flag stands for received data. The line error source is the OR of the overrun, parity, framing and break flags. The modem source is the OR of the four modem-change flags. The masked sources are ORed and registered, so the request line changes only on a clock edge and carries no glitches. The identification code and the status registers themselves are kept elsewhere.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask reads back as 0x00 and `irq` is low.
- R2: A write with `cpuWrEn` high stores `cpuWrData[3:0]` into the mask at the next clock edge. Bit 0 masks received data, bit 1 masks transmit empty, bit 2 masks line error and bit 3 masks modem change. `cpuRdData` always shows the mask in bits 3:0 and 0 in bits 7:4. Data written to bits 7:4 is ignored.
- R3: With `fifoMode` high, the received-data source is active when `rxFill >= rxTrigger` and inactive when `rxFill < rxTrigger`. `dataReady` has no effect in this mode.
- R4: With `fifoMode` low, the received-data source equals `dataReady`, and the FIFO fill has no effect.
- R5: The transmit source equals `thrEmpty`.
- R6: The line error source is high when any bit of `lineErr` is set (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break).
- R7: The modem source is high when any bit of `modemDelta` is set.
- R8: `irq` is a register. After each clock edge it holds the OR of the four sources, each ANDed with its mask bit, using the inputs and the mask as they were just before that edge. A source whose mask bit is 0 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWrEn | input | 1 | Mask write strobe |
| cpuWrData | input | 8 | Mask write data |
| cpuRdData | output | 8 | Mask read data |
| rxFill | input | FILL_W | Receive FIFO fill level |
| rxTrigger | input | FILL_W | Programmed receive trigger level |
| fifoMode | input | 1 | FIFO mode enable |
| dataReady | input | 1 | Receive data-ready flag |
| thrEmpty | input | 1 | Transmit holding register empty flag |
| lineErr | input | 4 | Overrun, parity, framing and break flags |
| modemDelta | input | 4 | Modem input change flags |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong mask bit appears right away in `cpuRdData`. It also shows as an `irq` that is missing or spurious one edge after the source it gates is applied. An off-by-one in the trigger comparison appears only when the fill equals the trigger level or sits one entry below it, so the directed cases hold exactly those two values. The random phase mixes all inputs with mask writes and checks `irq` every cycle, so a latency or gating fault is reported within one cycle of its first occurrence.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N = 4;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_LINE = 2;
  localparam int SRC_MODEM = 3;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic             loadMask;
    logic [SRC_N-1:0] newMask;
    logic             rxAvail;
  } irqStrobe_t;
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
#(
  parameter int FILL_W = 5
) (
  input  logic              cpuWrEn,
  input  logic [BUS_W-1:0]  cpuWrData,
  input  logic [FILL_W-1:0] rxFill,
  input  logic [FILL_W-1:0] rxTrigger,
  input  logic              fifoMode,
  input  logic              dataReady,
  output irqStrobe_t        strobe
);
  logic trigReached;

  // Trigger comparison: reached at the level, released below it.
  assign trigReached = (rxFill >= rxTrigger);

  always_comb begin
    strobe.loadMask = cpuWrEn;
    strobe.newMask  = cpuWrData[SRC_N-1:0];
    strobe.rxAvail  = fifoMode ? trigReached : dataReady;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int LINE_N = 4,
  parameter int MODEM_N = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic               thrEmpty,
  input  logic [LINE_N-1:0]  lineErr,
  input  logic [MODEM_N-1:0] modemDelta,
  output logic [BUS_W-1:0]   rdData,
  output logic               irq
);
  localparam int PAD_W = BUS_W - SRC_N;

  logic [SRC_N-1:0] maskQ;
  logic [SRC_N-1:0] srcVec;
  logic [SRC_N-1:0] gated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                maskQ <= '0;
    else if (strobe.loadMask) maskQ <= strobe.newMask;
  end

  always_comb begin
    srcVec            = '0;
    srcVec[SRC_RX]    = strobe.rxAvail;
    srcVec[SRC_TX]    = thrEmpty;
    srcVec[SRC_LINE]  = |lineErr;
    srcVec[SRC_MODEM] = |modemDelta;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_gate
    assign gated[g] = srcVec[g] & maskQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |gated;
  end

  assign rdData = {{PAD_W{1'b0}}, maskQ};

  // R2: a write lands in the mask one edge later
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadMask |=> (rdData[SRC_N-1:0] == $past(strobe.newMask)));
  // R2: without a write the mask holds
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadMask |=> $stable(maskQ));
  // R2: upper read bits are zero
  p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BUS_W-1:SRC_N] == '0);
  // R8: fully masked means quiet next cycle
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> !irq);
  // R5
  p_tx_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[SRC_TX] && thrEmpty) |=> irq);
  // R6
  p_line_raise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[SRC_LINE] && lineErr != '0) |=> irq);
  // R7
  p_modem_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[SRC_MODEM] && modemDelta != '0) |=> irq);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FILL_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [7:0]        cpuWrData,
  output logic [7:0]        cpuRdData,
  input  logic [FILL_W-1:0] rxFill,
  input  logic [FILL_W-1:0] rxTrigger,
  input  logic              fifoMode,
  input  logic              dataReady,
  input  logic              thrEmpty,
  input  logic [3:0]        lineErr,
  input  logic [3:0]        modemDelta,
  output logic              irq
);
  irqStrobe_t strobe;

  uart_irq_ctl #(.FILL_W(FILL_W)) ctl_i (
    .cpuWrEn   (cpuWrEn),
    .cpuWrData (cpuWrData),
    .rxFill    (rxFill),
    .rxTrigger (rxTrigger),
    .fifoMode  (fifoMode),
    .dataReady (dataReady),
    .strobe    (strobe)
  );

  uart_irq_dp #(.LINE_N(4), .MODEM_N(4)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .thrEmpty   (thrEmpty),
    .lineErr    (lineErr),
    .modemDelta (modemDelta),
    .rdData     (cpuRdData),
    .irq        (irq)
  );

  // R3: fill at or above trigger in FIFO mode raises the request when unmasked
  p_fifo_trig_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && cpuRdData[0] && rxFill >= rxTrigger) |=> irq);
  // R4: data-ready drives the receive source outside FIFO mode
  p_nofifo_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && cpuRdData[0] && dataReady) |=> irq);
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuWrEn = 1'b0;
  logic [7:0]    cpuWrData = '0;
  logic [7:0]    cpuRdData;
  logic [FW-1:0] rxFill = '0;
  logic [FW-1:0] rxTrigger = '0;
  logic          fifoMode = 1'b0;
  logic          dataReady = 1'b0;
  logic          thrEmpty = 1'b0;
  logic [3:0]    lineErr = '0;
  logic [3:0]    modemDelta = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [3:0] expMask = '0;
  logic expIrq = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.FILL_W(FW)) dut_i (.*);

  function automatic logic modelIrq(input logic [3:0] m);
    logic rxs;
    rxs = fifoMode ? (rxFill >= rxTrigger) : dataReady;
    return (m[0] & rxs) | (m[1] & thrEmpty) | (m[2] & (|lineErr)) | (m[3] & (|modemDelta));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs are set at a negedge; one posedge later, results are checked at the next negedge.
  task automatic step(input string req);
    expIrq = modelIrq(expMask);
    if (cpuWrEn) expMask = cpuWrData[3:0];
    @(posedge clk);
    @(negedge clk);
    check({req, " irq"}, {7'b0, irq}, {7'b0, expIrq});
    check("R2 readback", cpuRdData, {4'b0, expMask});
    cpuWrEn = 1'b0;
  endtask

  task automatic clearIn();
    rxFill = '0; rxTrigger = 5'd1; fifoMode = 1'b0; dataReady = 1'b0;
    thrEmpty = 1'b0; lineErr = '0; modemDelta = '0;
  endtask

  task automatic setMask(input logic [7:0] v);
    cpuWrEn = 1'b1; cpuWrData = v;
    step("R2 write");
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    check("R1 reset mask", cpuRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    clearIn();
    thrEmpty = 1'b1; lineErr = 4'hF; modemDelta = 4'hF; dataReady = 1'b1;
    step("R1 masked after reset");
    clearIn();

    setMask(8'hF5);   // R2: upper bits ignored
    check("R2 upper ignored", cpuRdData, 8'h05);

    // R3 boundary cases
    setMask(8'h01);
    fifoMode = 1'b1; rxTrigger = 5'd8; rxFill = 5'd8; dataReady = 1'b0;
    step("R3 at trigger");
    rxFill = 5'd7; dataReady = 1'b1;
    step("R3 below trigger");
    rxFill = 5'd16; rxTrigger = 5'd14;
    step("R3 above trigger");
    // R4
    clearIn(); dataReady = 1'b1; rxFill = 5'd0; rxTrigger = 5'd4;
    step("R4 ready");
    dataReady = 1'b0; rxFill = 5'd16;
    step("R4 fill ignored");
    // R5
    clearIn(); setMask(8'h02); thrEmpty = 1'b1;
    step("R5 tx empty");
    // R6: each flag
    clearIn(); setMask(8'h04);
    for (int b = 0; b < 4; b++) begin
      lineErr = 4'b1 << b;
      step("R6 line flag");
    end
    // R7: each flag, then masked
    clearIn(); setMask(8'h08);
    for (int b = 0; b < 4; b++) begin
      modemDelta = 4'b1 << b;
      step("R7 modem flag");
    end
    setMask(8'h07);
    step("R8 modem masked");

    // Random phase
    for (int i = 0; i < 2000; i++) begin
      fifoMode = 1'($urandom);
      rxFill = 5'($urandom_range(0, 16));
      rxTrigger = 5'($urandom_range(1, 16));
      dataReady = 1'($urandom);
      thrEmpty = (($urandom % 4) == 0);
      lineErr = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      modemDelta = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      cpuWrEn = (($urandom % 5) == 0);
      cpuWrData = 8'($urandom);
      step("R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule